// File: doc/BRIEF.md
# Reset Pin Manager with Pulse Shaper

This block looks after a bidirectional, active-low system reset line from a slow clock domain. The line is read through a two-stage synchronizer. A new low level on it is either reported to the reset sequencer as a user reset request or turned into an interrupt, depending on two mode bits. A sticky status flag records that the line went low and stays set until software reads the status register. The synchronized line level can be read at any time.

When the reset sequencer asks for an external reset, the block pulls the line low through an open-drain enable. It holds the line low for a number of slow clock cycles that is a power of two, chosen by a 4-bit length field in the mode register. A low level that the block causes itself is never taken as a new user event.

Register access uses a one-bit select. Select 0 is the mode register and select 1 is the status register. Reads are combinational. Writes to the status register have no effect.

Top module: `rst_pin_mgr`

## Requirements
- R1: The line level is used only after two slow clock flops. A change on `pin_in` shows in status bit 0 after the second rising edge that follows it.
- R2: A high-to-low transition of the synchronized level raises `user_rst` for exactly one cycle, when mode bit 0 (user reset enable) is 1 and mode bit 1 (interrupt enable) is 0.
- R3: With mode bit 0 at 0 and mode bit 1 at 0, a line assertion gives no `user_rst` and no `irq`.
- R4: With mode bit 1 at 1, a line assertion gives no `user_rst`. It raises `irq` one cycle after the transition is seen, and `irq` stays high until the status flag is cleared.
- R5: Status bit 1 (event flag) is set by a line assertion and cleared by a status read (`reg_rd` with `reg_sel` = 1), and not by anything else.
- R6: If a status read and a new assertion fall on the same clock edge, the event flag stays set.
- R7: An external reset request drives `pin_drive_low` high for exactly 2^(L+1) cycles, where L is mode bits 7:4. L = 0 gives 2 cycles and L = 15 gives 65536 cycles.
- R8: A low level on the line caused by the block's own pulse sets no event flag and raises neither `user_rst` nor `irq`.
- R9: A request that arrives while a pulse is running is ignored. The running pulse keeps its original length.
- R10: After reset the mode register reads 0x01, status reads 0x01 with the line high, and `pin_drive_low`, `user_rst` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pin_in | input | 1 | Sampled level of the reset line |
| pin_drive_low | output | 1 | Open-drain enable, 1 pulls the line low |
| ext_rst_req | input | 1 | External reset request from the sequencer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects mode, 1 selects status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| user_rst | output | 1 | One-cycle user reset request to the sequencer |
| irq | output | 1 | Interrupt, held while the event flag is set and interrupts are enabled |

## Verification
Two functions can act on the same edge: a status read that clears the event flag, and a new line assertion that sets it. The bench first leaves the flag set by an earlier event. It then pulls the line low and times a status read so that the read strobe is high on the edge where the synchronized falling edge is seen. The flag and `irq` must still be set afterwards. A second read must clear the flag, which shows that the first read did not swallow the event.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int LEN_W = 4;
  localparam int CNT_W = (1 << LEN_W) + 1;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [1:0]       rsvd;
    logic             irq_en;
    logic             urst_en;
  } mode_t;

  // Pulse length in cycles: 2^(len+1)
  function automatic logic [31:0] pulse_cycles(input logic [LEN_W-1:0] len);
    return 32'd1 << (32'(len) + 32'd1);
  endfunction
endpackage

// File: rtl/rpm_sync.sv
module rpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rpm_pulse.sv
module rpm_pulse
  import rpm_pkg::*;
#(
  parameter int LW = LEN_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [LW-1:0] len_i,
  output logic          drv_o,
  output logic          start_o
);
  logic [CW-1:0] cnt;
  logic          last;

  assign start_o = req_i && !drv_o;
  assign last    = drv_o && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_o <= 1'b0;
      cnt   <= '0;
    end else if (start_o) begin
      drv_o <= 1'b1;
      cnt   <= CW'(pulse_cycles(len_i) - 32'd1);
    end else if (last) begin
      drv_o <= 1'b0;
    end else if (drv_o) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R9
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_o && cnt != '0) |=> (drv_o && cnt == $past(cnt) - 1'b1));
  // R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !drv_o);
endmodule

// File: rtl/rpm_event.sv
module rpm_event (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic self_start_i,
  input  logic self_drv_i,
  input  logic urst_en_i,
  input  logic irq_en_i,
  input  logic rd_clr_i,
  output logic sticky_o,
  output logic user_rst_o,
  output logic irq_o
);
  logic lvl_q;
  logic self_flag;
  logic fall_evt;

  assign fall_evt   = lvl_q && !lvl_i && !self_flag;
  assign user_rst_o = fall_evt && urst_en_i && !irq_en_i;
  assign irq_o      = sticky_o && irq_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= 1'b1;
      self_flag <= 1'b0;
      sticky_o  <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (self_start_i)                 self_flag <= 1'b1;
      else if (!self_drv_i && lvl_i)    self_flag <= 1'b0;
      if (fall_evt)                     sticky_o  <= 1'b1;
      else if (rd_clr_i)                sticky_o  <= 1'b0;
    end
  end

  // R2
  user_rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_rst_o |=> !user_rst_o);
  // R6
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> sticky_o);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !fall_evt) |=> !sticky_o);
  // R8
  no_self_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_drv_i |-> !user_rst_o);
endmodule

// File: rtl/rst_pin_mgr.sv
module rst_pin_mgr
  import rpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_slow,
  input  logic       rst_n,
  input  logic       pin_in,
  output logic       pin_drive_low,
  input  logic       ext_rst_req,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       user_rst,
  output logic       irq
);
  mode_t mode;
  logic  lvl_sync;
  logic  sticky;
  logic  pulse_start;
  logic  stat_rd;

  assign stat_rd = reg_rd && reg_sel;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '{len: '0, rsvd: '0, irq_en: 1'b0, urst_en: 1'b1};
    end else if (reg_wr && !reg_sel) begin
      mode      <= mode_t'(wdata);
      mode.rsvd <= '0;
    end
  end

  assign rdata = reg_sel ? {6'b0, sticky, lvl_sync} : 8'(mode);

  rpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_slow), .rst_n(rst_n), .d_i(pin_in), .q_o(lvl_sync)
  );

  rpm_pulse u_pulse (
    .clk(clk_slow), .rst_n(rst_n), .req_i(ext_rst_req), .len_i(mode.len),
    .drv_o(pin_drive_low), .start_o(pulse_start)
  );

  rpm_event u_event (
    .clk(clk_slow), .rst_n(rst_n), .lvl_i(lvl_sync),
    .self_start_i(pulse_start), .self_drv_i(pin_drive_low),
    .urst_en_i(mode.urst_en), .irq_en_i(mode.irq_en), .rd_clr_i(stat_rd),
    .sticky_o(sticky), .user_rst_o(user_rst), .irq_o(irq)
  );

  // R4
  irq_excludes_reset_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
    irq |-> !user_rst);
endmodule

// File: tb/rst_pin_mgr_tb.sv
module rst_pin_mgr_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_low = 1'b0;
  logic       pin_in;
  logic       pin_drive_low;
  logic       ext_rst_req = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       user_rst, irq;
  int         n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pin_in = ~(ext_low | pin_drive_low);

  rst_pin_mgr u_dut (
    .clk_slow(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
    .ext_rst_req(ext_rst_req), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .user_rst(user_rst), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [7:0] v);
    reg_wr = 1'b1; reg_sel = 1'b0; wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // called at a negedge; samples status, then clears it on the next edge
  task automatic read_status(output logic [7:0] v);
    reg_rd = 1'b1; reg_sel = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek_status(output logic [7:0] v);
    reg_sel = 1'b1;
    #1 v = rdata;
    reg_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_sel = 1'b0; #1;
    check(rdata == 8'h01, "R10 mode", rdata, 8'h01);
    peek_status(v);
    check(v == 8'h01, "R10 status", v, 8'h01);
    check(!pin_drive_low && !user_rst && !irq, "R10 outputs",
          {pin_drive_low, user_rst, irq}, 0);
  endtask

  task automatic t_sync_level();
    logic [7:0] v;
    write_mode(8'h00);
    ext_low = 1'b1;
    @(negedge clk);
    peek_status(v);
    check(v[0] == 1'b1, "R1 one flop", v[0], 1);
    @(negedge clk);
    peek_status(v);
    check(v[0] == 1'b0, "R1 two flops", v[0], 0);
    ext_low = 1'b0;
    settle();
    read_status(v);
  endtask

  task automatic t_user_reset();
    logic [7:0] v;
    write_mode(8'h01);
    read_status(v);
    ext_low = 1'b1;
    @(negedge clk); @(negedge clk);
    check(user_rst == 1'b1, "R2 user_rst high", user_rst, 1);
    check(irq == 1'b0, "R2 no irq", irq, 0);
    @(negedge clk);
    check(user_rst == 1'b0, "R2 one cycle", user_rst, 0);
    read_status(v);
    check(v[1] == 1'b1, "R5 flag set", v[1], 1);
    peek_status(v);
    check(v[1] == 1'b0, "R5 flag cleared by read", v[1], 0);
    ext_low = 1'b0;
    settle();
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    write_mode(8'h00);
    ext_low = 1'b1;
    @(negedge clk); @(negedge clk);
    check(user_rst == 1'b0, "R3 no user_rst", user_rst, 0);
    @(negedge clk);
    check(irq == 1'b0, "R3 no irq", irq, 0);
    ext_low = 1'b0;
    settle();
    peek_status(v);
    check(v[1] == 1'b1, "R5 flag held without read", v[1], 1);
    read_status(v);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    write_mode(8'h03);
    ext_low = 1'b1;
    @(negedge clk); @(negedge clk);
    check(user_rst == 1'b0, "R4 no user_rst", user_rst, 0);
    check(irq == 1'b0, "R4 irq not yet", irq, 0);
    @(negedge clk);
    check(irq == 1'b1, "R4 irq raised", irq, 1);
    ext_low = 1'b0;
    settle();
    check(irq == 1'b1, "R4 irq held", irq, 1);
    read_status(v);
    check(irq == 1'b0, "R4 irq cleared by read", irq, 0);
  endtask

  task automatic t_race();
    logic [7:0] v;
    write_mode(8'h02);
    ext_low = 1'b1; settle(); ext_low = 1'b0; settle();
    ext_low = 1'b1;
    @(negedge clk); @(negedge clk);
    read_status(v);
    check(v[1] == 1'b1, "R6 flag before race", v[1], 1);
    peek_status(v);
    check(v[1] == 1'b1, "R6 flag kept after race", v[1], 1);
    check(irq == 1'b1, "R6 irq kept", irq, 1);
    read_status(v);
    peek_status(v);
    check(v[1] == 1'b0, "R6 later read clears", v[1], 0);
    ext_low = 1'b0;
    settle();
  endtask

  task automatic t_pulse(input int len, input bool_busy);
    logic [7:0] v;
    int cnt = 0;
    bit saw_evt = 1'b0;
    write_mode(8'((len << 4) | 1));
    read_status(v);
    ext_rst_req = 1'b1;
    @(negedge clk);
    ext_rst_req = 1'b0;
    while (pin_drive_low && cnt < 70000) begin
      cnt++;
      if (user_rst) saw_evt = 1'b1;
      if (bool_busy && cnt == 3) ext_rst_req = 1'b1;
      if (bool_busy && cnt == 5) ext_rst_req = 1'b0;
      @(negedge clk);
    end
    ext_rst_req = 1'b0;
    check(cnt == (1 << (len + 1)), bool_busy ? "R9 busy request ignored" : "R7 pulse length",
          cnt, 1 << (len + 1));
    settle();
    if (user_rst) saw_evt = 1'b1;
    peek_status(v);
    check(!saw_evt && v[1] == 1'b0, "R8 own pulse no event", {saw_evt, v[1]}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_level();
    t_user_reset();
    t_disabled();
    t_irq();
    t_race();
    t_pulse(0, 1'b0);
    t_pulse(3, 1'b0);
    t_pulse(2, 1'b1);
    t_pulse(15, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule